// File: doc/BRIEF.md
# Three-Level Longest-Prefix Lookup Sequencer

This block steers one IPv4 longest-prefix lookup through a compressed trie that is split into three levels. The top sixteen address bits go to a level-one search engine. The pointer that comes back either carries the final next-hop index or names a chunk at the next level. In the second case the sequencer passes the next address byte to the chunk search engine that handles that chunk's encoding. There is one engine for sparse chunks (1 to 8 heads), one for dense chunks (9 to 64 heads) and one for very dense chunks (65 to 256 heads). The same step is repeated for the third level with the lowest address byte.

Each engine search costs between one and four memory reads, so a complete lookup never needs more than twelve. The sequencer holds exactly one lookup at a time. A new address is taken only after the previous result has been consumed. If the third level returns a chunk pointer, the tables are malformed. The sequencer then reports a reserved undefined next-hop and raises an error flag instead of descending further.

Top module: `lpm_lookup_seq`

## Requirements
- R1: After reset the block is ready for an address, holds no result and drives no engine request.
- R2: An address is captured only when `req_valid` and `req_ready` are both high. `req_ready` stays low from that capture until the result handshake, and addresses offered in between are ignored.
- R3: Each lookup issues exactly one level-one request, whose key is bits 31:16 of the captured address. The request and its key are held until `l1_req_ready`.
- R4: A pointer is 16 bits: bits 15:14 give its kind (00 next-hop, 01 sparse chunk, 10 dense chunk, 11 very dense chunk) and bits 13:0 give the index. A kind of 00 ends the lookup with that index on `res_hop` and `res_err` low. This includes the all-ones index when it comes from a valid next-hop.
- R5: A chunk pointer from level one raises exactly one bit of `ch_req_valid`: bit 0 for sparse, bit 1 for dense, bit 2 for very dense. The request carries the chunk index, `ch_req_level` = 2 and key = address bits 15:8.
- R6: A chunk pointer from level two raises a request to the engine of its kind, with `ch_req_level` = 3 and key = address bits 7:0.
- R7: A chunk pointer from level three ends the lookup with `res_hop` = 14'h3FFF and `res_err` high.
- R8: While `res_valid` is high and `res_ready` is low, `res_valid`, `res_hop` and `res_err` stay unchanged.
- R9: A response is taken only from the engine that holds the outstanding request, and only after that request has been accepted. Responses on any other engine port are ignored.
- R10: At most one engine request is valid in any cycle, and no lookup issues more than three engine requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Address offered |
| req_ready | output | 1 | Sequencer idle, address can be taken |
| req_addr | input | 32 | Destination address |
| res_valid | output | 1 | Result available |
| res_ready | input | 1 | Result consumed |
| res_hop | output | 14 | Next-hop index |
| res_err | output | 1 | Chunk pointer seen at the deepest level |
| l1_req_valid | output | 1 | Level-one search request |
| l1_req_ready | input | 1 | Level-one engine accepts request |
| l1_req_key | output | 16 | Level-one search key (address bits 31:16) |
| l1_rsp_valid | input | 1 | Level-one pointer returned |
| l1_rsp_ptr | input | 16 | Level-one pointer |
| ch_req_valid | output | 3 | Chunk request, one bit per engine (sparse, dense, very dense) |
| ch_req_ready | input | 3 | Chunk engine accepts request |
| ch_req_index | output | 14 | Chunk index within the level |
| ch_req_key | output | 8 | Address byte for the chunk search |
| ch_req_level | output | 2 | Level searched (2 or 3) |
| ch_rsp_valid | input | 3 | Chunk engine pointer returned |
| ch_rsp_ptr | input | 48 | Engine pointers, engine e at bits 16e+15:16e |

## Verification
The sweep walks every combination of pointer kinds across the three levels, each with four different address patterns. This separates termination at level one, two and three from the error exit, and shows that each chunk kind reaches its own engine with the correct byte. The engine models apply changing acceptance stalls and response latencies. While waiting, they also emit a stray next-hop on an engine that was not asked, which exposes any response taken from the wrong port or at the wrong time. A foreign address stays offered throughout each lookup, and the consumer delays taking the result. This tests whether the captured address is kept and whether the result stays stable. A directed all-ones next-hop from level one tells a genuine maximum index apart from the error code.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    // Address and key geometry
    localparam int ADDR_W      = 32;
    localparam int L1_KEY_W    = 16;
    localparam int CK_KEY_W    = 8;
    localparam int N_LEVELS    = 3;
    localparam int LVL_W       = $clog2(N_LEVELS + 1);

    // Pointer geometry: kind in the top bits, index below
    localparam int KIND_W      = 2;
    localparam int PTR_W       = 16;
    localparam int IDX_W       = PTR_W - KIND_W;
    localparam int N_ENG       = (1 << KIND_W) - 1;

    // Derived constants
    localparam int FIRST_CH_LVL  = 2;
    localparam int CH_BASE_SHIFT = ADDR_W - L1_KEY_W - CK_KEY_W;
    localparam logic [IDX_W-1:0] UNDEF_HOP = '1;

    typedef logic [LVL_W-1:0] level_t;

    typedef enum logic [KIND_W-1:0] {
        PK_HOP    = 2'b00,
        PK_SPARSE = 2'b01,
        PK_DENSE  = 2'b10,
        PK_VDENSE = 2'b11
    } ptr_kind_e;

    typedef struct packed {
        ptr_kind_e        kind;
        logic [IDX_W-1:0] idx;
    } lpm_ptr_t;

    typedef enum logic [2:0] {
        S_IDLE,
        S_L1_REQ,
        S_L1_WAIT,
        S_CH_REQ,
        S_CH_WAIT,
        S_DONE
    } seq_state_e;

    localparam level_t LVL_FIRST_CH = level_t'(FIRST_CH_LVL);
    localparam level_t LVL_LAST     = level_t'(N_LEVELS);

    // Reinterpret a raw bus word as a pointer
    function automatic lpm_ptr_t to_ptr(input logic [PTR_W-1:0] raw);
        return lpm_ptr_t'(raw);
    endfunction

    // Top key used by the first level
    function automatic logic [L1_KEY_W-1:0] first_key(input logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: L1_KEY_W];
    endfunction

    // Address byte consumed by a chunk level (deeper level -> lower byte)
    function automatic logic [CK_KEY_W-1:0] chunk_key(input logic [ADDR_W-1:0] a,
                                                      input level_t           lv);
        logic [ADDR_W-1:0] sh;
        sh = a >> (CH_BASE_SHIFT - (int'(lv) - FIRST_CH_LVL) * CK_KEY_W);
        return sh[CK_KEY_W-1:0];
    endfunction

    // Engine slot that serves a chunk kind (0 = sparse)
    function automatic ptr_kind_e kind_of_slot(input int slot);
        return ptr_kind_e'(KIND_W'(slot + 1));
    endfunction

endpackage

// File: rtl/lpm_req_fanout.sv
// Turns one chunk request into a one-hot valid towards the engine of its kind
module lpm_req_fanout
    import lpm_pkg::*;
#(
    parameter int N = N_ENG
) (
    input  logic         go,
    input  ptr_kind_e    kind,
    input  logic [N-1:0] eng_ready,
    output logic [N-1:0] eng_valid,
    output logic         acc
);

    genvar e;
    generate
        for (e = 0; e < N; e++) begin : g_slot
            assign eng_valid[e] = go && (kind == kind_of_slot(e));
        end
    endgenerate

    assign acc = |(eng_valid & eng_ready);

endmodule

// File: rtl/lpm_rsp_select.sv
// Picks the response of the engine that owns the outstanding request
module lpm_rsp_select
    import lpm_pkg::*;
#(
    parameter int N = N_ENG
) (
    input  logic               wait_en,
    input  ptr_kind_e          kind,
    input  logic [N-1:0]       rsp_valid,
    input  logic [N*PTR_W-1:0] rsp_flat,
    output logic               hit,
    output lpm_ptr_t           ptr
);

    logic [N-1:0] match;

    genvar e;
    generate
        for (e = 0; e < N; e++) begin : g_match
            assign match[e] = wait_en && rsp_valid[e] && (kind == kind_of_slot(e));
        end
    endgenerate

    always_comb begin
        ptr = '0;
        for (int s = 0; s < N; s++) begin
            if (match[s]) begin
                ptr = to_ptr(rsp_flat[s*PTR_W +: PTR_W]);
            end
        end
    end

    assign hit = |match;

endmodule

// File: rtl/lpm_seq_ctrl.sv
// Lookup state machine: captures the address, walks up to three levels
module lpm_seq_ctrl
    import lpm_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    // address side
    input  logic                req_valid,
    input  logic [ADDR_W-1:0]   req_addr,
    output logic                req_ready,
    // result side
    output logic                res_valid,
    input  logic                res_ready,
    output logic [IDX_W-1:0]    res_hop,
    output logic                res_err,
    // level-one engine
    output logic                l1_go,
    output logic [L1_KEY_W-1:0] l1_key,
    input  logic                l1_acc,
    input  logic                l1_hit,
    input  lpm_ptr_t            l1_ptr,
    // chunk engines (after fan-out / selection)
    output logic                ch_go,
    output logic                ch_wait,
    output ptr_kind_e           ch_kind,
    output logic [IDX_W-1:0]    ch_index,
    output logic [CK_KEY_W-1:0] ch_key,
    output level_t              ch_level,
    input  logic                ch_acc,
    input  logic                ch_hit,
    input  lpm_ptr_t            ch_ptr
);

    seq_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    ptr_kind_e         kind_q;
    logic [IDX_W-1:0]  idx_q;
    level_t            level_q;
    logic [IDX_W-1:0]  hop_q;
    logic              err_q;

    // Resolution of whichever level is currently being awaited
    logic     rsp_hit;
    lpm_ptr_t rsp_ptr;
    logic     at_last;
    level_t   next_level;

    always_comb begin
        rsp_hit    = 1'b0;
        rsp_ptr    = l1_ptr;
        at_last    = 1'b0;
        next_level = LVL_FIRST_CH;
        if (state_q == S_L1_WAIT) begin
            rsp_hit = l1_hit;
        end else if (state_q == S_CH_WAIT) begin
            rsp_hit    = ch_hit;
            rsp_ptr    = ch_ptr;
            at_last    = (level_q == LVL_LAST);
            next_level = level_q + level_t'(1);
        end
    end

    // Port drive
    assign req_ready = (state_q == S_IDLE);
    assign res_valid = (state_q == S_DONE);
    assign res_hop   = hop_q;
    assign res_err   = err_q;
    assign l1_go     = (state_q == S_L1_REQ);
    assign l1_key    = first_key(addr_q);
    assign ch_go     = (state_q == S_CH_REQ);
    assign ch_wait   = (state_q == S_CH_WAIT);
    assign ch_kind   = kind_q;
    assign ch_index  = idx_q;
    assign ch_level  = level_q;
    assign ch_key    = chunk_key(addr_q, level_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= S_IDLE;
            addr_q  <= '0;
            kind_q  <= PK_HOP;
            idx_q   <= '0;
            level_q <= '0;
            hop_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                S_IDLE: begin
                    if (req_valid) begin
                        addr_q  <= req_addr;
                        err_q   <= 1'b0;
                        state_q <= S_L1_REQ;
                    end
                end
                S_L1_REQ: begin
                    if (l1_acc) state_q <= S_L1_WAIT;
                end
                S_CH_REQ: begin
                    if (ch_acc) state_q <= S_CH_WAIT;
                end
                S_L1_WAIT, S_CH_WAIT: begin
                    if (rsp_hit) begin
                        if (rsp_ptr.kind == PK_HOP) begin
                            hop_q   <= rsp_ptr.idx;
                            err_q   <= 1'b0;
                            state_q <= S_DONE;
                        end else if (at_last) begin
                            hop_q   <= UNDEF_HOP;
                            err_q   <= 1'b1;
                            state_q <= S_DONE;
                        end else begin
                            kind_q  <= rsp_ptr.kind;
                            idx_q   <= rsp_ptr.idx;
                            level_q <= next_level;
                            state_q <= S_CH_REQ;
                        end
                    end
                end
                S_DONE: begin
                    if (res_ready) state_q <= S_IDLE;
                end
                default: state_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lpm_lookup_seq.sv
// Top: three-level longest-prefix lookup sequencer
module lpm_lookup_seq
    import lpm_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [ADDR_W-1:0]      req_addr,
    output logic                   res_valid,
    input  logic                   res_ready,
    output logic [IDX_W-1:0]       res_hop,
    output logic                   res_err,
    output logic                   l1_req_valid,
    input  logic                   l1_req_ready,
    output logic [L1_KEY_W-1:0]    l1_req_key,
    input  logic                   l1_rsp_valid,
    input  logic [PTR_W-1:0]       l1_rsp_ptr,
    output logic [N_ENG-1:0]       ch_req_valid,
    input  logic [N_ENG-1:0]       ch_req_ready,
    output logic [IDX_W-1:0]       ch_req_index,
    output logic [CK_KEY_W-1:0]    ch_req_key,
    output logic [LVL_W-1:0]       ch_req_level,
    input  logic [N_ENG-1:0]       ch_rsp_valid,
    input  logic [N_ENG*PTR_W-1:0] ch_rsp_ptr
);

    logic      ch_go;
    logic      ch_wait;
    ptr_kind_e ch_kind;
    logic      ch_acc;
    logic      ch_hit;
    lpm_ptr_t  ch_ptr;
    level_t    ch_level;

    lpm_seq_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_ready (req_ready),
        .res_valid (res_valid),
        .res_ready (res_ready),
        .res_hop   (res_hop),
        .res_err   (res_err),
        .l1_go     (l1_req_valid),
        .l1_key    (l1_req_key),
        .l1_acc    (l1_req_valid && l1_req_ready),
        .l1_hit    (l1_rsp_valid),
        .l1_ptr    (to_ptr(l1_rsp_ptr)),
        .ch_go     (ch_go),
        .ch_wait   (ch_wait),
        .ch_kind   (ch_kind),
        .ch_index  (ch_req_index),
        .ch_key    (ch_req_key),
        .ch_level  (ch_level),
        .ch_acc    (ch_acc),
        .ch_hit    (ch_hit),
        .ch_ptr    (ch_ptr)
    );

    lpm_req_fanout #(.N(N_ENG)) u_fanout (
        .go        (ch_go),
        .kind      (ch_kind),
        .eng_ready (ch_req_ready),
        .eng_valid (ch_req_valid),
        .acc       (ch_acc)
    );

    lpm_rsp_select #(.N(N_ENG)) u_select (
        .wait_en   (ch_wait),
        .kind      (ch_kind),
        .rsp_valid (ch_rsp_valid),
        .rsp_flat  (ch_rsp_ptr),
        .hit       (ch_hit),
        .ptr       (ch_ptr)
    );

    assign ch_req_level = ch_level;

endmodule

// File: rtl/lpm_lookup_seq_chk.sv
module lpm_lookup_seq_chk
    import lpm_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                req_valid,
    input logic                req_ready,
    input logic                res_valid,
    input logic                res_ready,
    input logic [IDX_W-1:0]    res_hop,
    input logic                res_err,
    input logic                l1_req_valid,
    input logic                l1_req_ready,
    input logic [L1_KEY_W-1:0] l1_req_key,
    input logic [N_ENG-1:0]    ch_req_valid,
    input logic [N_ENG-1:0]    ch_req_ready,
    input logic [LVL_W-1:0]    ch_req_level
);

    // Engine requests issued since the last address capture
    logic [2:0] n_issued;
    always_ff @(posedge clk) begin
        if (rst) begin
            n_issued <= '0;
        end else if (req_valid && req_ready) begin
            n_issued <= '0;
        end else begin
            n_issued <= n_issued + 3'(l1_req_valid && l1_req_ready)
                                 + 3'(|(ch_req_valid & ch_req_ready));
        end
    end

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (req_ready && !res_valid && !l1_req_valid && ch_req_valid == '0));

    // R2
    busy_block_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> !req_ready);

    // R3
    l1_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (l1_req_valid && !l1_req_ready) |=> (l1_req_valid && $stable(l1_req_key)));

    // R5
    ch_level_chk: assert property (@(posedge clk) disable iff (rst)
        (ch_req_valid != '0) |-> (ch_req_level == 2'd2 || ch_req_level == 2'd3));

    // R7
    err_code_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_err) |-> (res_hop == UNDEF_HOP));

    // R8
    res_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (res_valid && !res_ready) |=> (res_valid && $stable(res_hop) && $stable(res_err)));

    // R10
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({l1_req_valid, ch_req_valid}));

    // R10
    lvl_bound_chk: assert property (@(posedge clk) disable iff (rst)
        n_issued <= 3'd3);

endmodule

bind lpm_lookup_seq lpm_lookup_seq_chk u_chk (.*);

// File: tb/lpm_lookup_seq_test.sv
`timescale 1ns/1ps
module lpm_lookup_seq_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic        res_valid;
    logic        res_ready;
    logic [13:0] res_hop;
    logic        res_err;
    logic        l1_req_valid;
    logic        l1_req_ready;
    logic [15:0] l1_req_key;
    logic        l1_rsp_valid;
    logic [15:0] l1_rsp_ptr;
    logic [2:0]  ch_req_valid;
    logic [2:0]  ch_req_ready;
    logic [13:0] ch_req_index;
    logic [7:0]  ch_req_key;
    logic [1:0]  ch_req_level;
    logic [2:0]  ch_rsp_valid;
    logic [47:0] ch_rsp_ptr;

    lpm_lookup_seq uut (.*);

    always #2.5 clk = ~clk;

    int n_chk  = 0;
    int n_fail = 0;
    logic [31:0] cur_addr = '0;
    int cfg_stall = 0;
    int cfg_lat   = 1;
    bit finished  = 0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Bench-side tables, computed arithmetically
    function automatic logic [15:0] l1_tab(input logic [15:0] k);
        return {k[1:0], k[15:2]};
    endfunction
    function automatic logic [15:0] l2_tab(input logic [13:0] ix, input logic [7:0] k);
        return {k[1:0], ix ^ {6'd0, k}};
    endfunction
    function automatic logic [15:0] l3_tab(input logic [13:0] ix, input logic [7:0] k);
        return {k[1:0], 14'(ix + {6'd0, k})};
    endfunction

    // Engine models: stalls, latency, stray responses on idle engines
    initial begin : eng_model
        int pend;
        int stall_left;
        bit in_req;
        bit served_l1;
        logic [15:0] cap_key;
        logic [13:0] cap_idx;
        logic [1:0]  cap_lvl;
        int          cap_eng;
        logic [15:0] last_ptr;
        logic [1:0]  exp_lvl;
        pend = 0; stall_left = 0; in_req = 0; served_l1 = 0;
        cap_key = '0; cap_idx = '0; cap_lvl = '0; cap_eng = 0;
        last_ptr = '0; exp_lvl = 2'd2;
        l1_req_ready = 0; l1_rsp_valid = 0; l1_rsp_ptr = '0;
        ch_req_ready = '0; ch_rsp_valid = '0; ch_rsp_ptr = '0;
        forever begin
            @(negedge clk);
            l1_rsp_valid = 0;
            ch_rsp_valid = '0;
            l1_req_ready = 0;
            ch_req_ready = '0;
            if (pend > 0) begin
                pend--;
                if (pend == 0) begin
                    if (served_l1) begin
                        last_ptr = l1_tab(cap_key);
                        l1_rsp_ptr = last_ptr;
                        l1_rsp_valid = 1;
                        // stray next-hop on a chunk engine while level one is awaited (R9)
                        ch_rsp_valid[cur_addr[3:2] % 3] = 1'b1;
                        ch_rsp_ptr = {3{16'h0123}};
                        exp_lvl = 2'd2;
                    end else begin
                        last_ptr = (cap_lvl == 2'd2) ? l2_tab(cap_idx, cap_key[7:0])
                                                     : l3_tab(cap_idx, cap_key[7:0]);
                        ch_rsp_ptr = {3{16'h0777}};
                        ch_rsp_ptr[cap_eng*16 +: 16] = last_ptr;
                        ch_rsp_valid[cap_eng] = 1'b1;
                        ch_rsp_valid[(cap_eng + 1) % 3] = 1'b1;  // stray (R9)
                        exp_lvl = 2'd3;
                    end
                end
            end
            if ((l1_req_valid || ch_req_valid != '0) && pend == 0) begin
                if (!in_req) begin
                    in_req = 1;
                    stall_left = cfg_stall;
                end
                if (stall_left > 0) begin
                    stall_left--;
                end else begin
                    in_req = 0;
                    pend = cfg_lat;
                    if (l1_req_valid) begin
                        l1_req_ready = 1;
                        served_l1 = 1;
                        cap_key = l1_req_key;
                        chk(l1_req_key == cur_addr[31:16] && ch_req_valid == '0,
                            "R3 level-one key", l1_req_key, cur_addr[31:16]);
                    end else begin
                        served_l1 = 0;
                        cap_eng = int'(last_ptr[15:14]) - 1;
                        cap_idx = ch_req_index;
                        cap_lvl = ch_req_level;
                        cap_key = {8'd0, ch_req_key};
                        ch_req_ready = ch_req_valid;
                        if (exp_lvl == 2'd2) begin
                            chk(ch_req_valid == 3'(1 << cap_eng), "R5 engine select",
                                ch_req_valid, 3'(1 << cap_eng));
                            chk(ch_req_index == last_ptr[13:0] && ch_req_level == 2'd2 &&
                                ch_req_key == cur_addr[15:8], "R5 index/level/key",
                                {ch_req_level, ch_req_index, ch_req_key},
                                {2'd2, last_ptr[13:0], cur_addr[15:8]});
                        end else begin
                            chk(ch_req_valid == 3'(1 << cap_eng), "R6 engine select",
                                ch_req_valid, 3'(1 << cap_eng));
                            chk(ch_req_index == last_ptr[13:0] && ch_req_level == 2'd3 &&
                                ch_req_key == cur_addr[7:0], "R6 index/level/key",
                                {ch_req_level, ch_req_index, ch_req_key},
                                {2'd3, last_ptr[13:0], cur_addr[7:0]});
                        end
                        chk(!l1_req_valid, "R10 single request", l1_req_valid, 0);
                    end
                end
            end
        end
    end

    task automatic do_lookup(input logic [31:0] a, input int n);
        logic [15:0] p;
        logic [13:0] e_hop;
        bit          e_err;
        string       tag;
        int          guard;
        // expected walk from the requirements
        e_err = 0;
        p = l1_tab(a[31:16]);
        tag = "R4";
        if (p[15:14] != 2'b00) begin
            p = l2_tab(p[13:0], a[15:8]);
            tag = "R5";
            if (p[15:14] != 2'b00) begin
                p = l3_tab(p[13:0], a[7:0]);
                tag = "R6";
                if (p[15:14] != 2'b00) begin
                    e_err = 1;
                    tag = "R7";
                end
            end
        end
        e_hop = e_err ? 14'h3FFF : p[13:0];

        cfg_stall = n % 3;
        cfg_lat   = 1 + (n % 2);
        cur_addr  = a;
        @(negedge clk);
        req_valid = 1;
        req_addr  = a;
        @(negedge clk);
        chk(req_ready == 0, "R2 busy after capture", req_ready, 0);
        req_addr = ~a;  // foreign address kept offered (R2)
        guard = 0;
        while (!res_valid && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        chk(res_hop == e_hop && res_err == e_err, {tag, " result"},
            {res_err, res_hop}, {e_err, e_hop});
        chk(req_ready == 0, "R2 no capture while holding result", req_ready, 0);
        repeat (n % 4) @(negedge clk);
        if (n % 4 != 0)
            chk(res_valid && res_hop == e_hop && res_err == e_err, "R8 hold result",
                {res_valid, res_err, res_hop}, {1'b1, e_err, e_hop});
        res_ready = 1;
        req_valid = 0;
        @(negedge clk);
        res_ready = 0;
        chk(!res_valid && req_ready, "R2 idle after result", {res_valid, req_ready}, 2'b01);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        int n;
        rst = 1; req_valid = 0; req_addr = '0; res_ready = 0;
        repeat (5) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk(req_ready && !res_valid && !l1_req_valid && ch_req_valid == '0,
            "R1 reset state", {req_ready, res_valid, l1_req_valid, ch_req_valid}, 6'b100000);
        n = 0;
        for (int v = 0; v < 4; v++) begin
            for (int k1 = 0; k1 < 4; k1++) begin
                for (int k2 = 0; k2 < 4; k2++) begin
                    for (int k3 = 0; k3 < 4; k3++) begin
                        logic [13:0] hi;
                        logic [5:0]  mid;
                        logic [5:0]  lo;
                        hi  = 14'(v * 4099 + k3 * 17 + k2 * 3);
                        mid = 6'(v * 11 + k1 * 5);
                        lo  = 6'(v * 7 + k2 + k3 * 9);
                        do_lookup({hi, 2'(k1), mid, 2'(k2), lo, 2'(k3)}, n);
                        n++;
                    end
                end
            end
        end
        // R4: genuine all-ones next-hop from level one, error stays low
        do_lookup({14'h3FFF, 2'b00, 16'hA5C3}, 5);
        // R7: every level returns a chunk pointer
        do_lookup({14'h0001, 2'b11, 6'h00, 2'b10, 6'h00, 2'b01}, 2);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule